// File: doc/BRIEF.md
# Command Packet Framer and Checker

This block sits behind a byte receiver, such as a serial receiver, and turns the incoming byte stream into command packets. It stays in a hunt state and drops bytes until it sees the start flag. It then collects a fixed-order header: a tracking tag, a target block number, an operation code and a 16-bit payload byte count with the high byte first. The header values are held on output registers.

Payload bytes are passed on as a stream as they arrive, and the final payload byte is marked. A one-byte CRC follows the payload, and a constant end flag closes the packet. At the end the block raises a one-clock good strobe or a one-clock error strobe with a cause code. After any error it goes back to hunting.

Every output is registered, so each output responds one clock after the input byte that causes it. The start flag, the end flag and the idle limit are parameters.

Top module: `pkt_parser`

## Requirements
- R1: After a synchronous reset the parser is hunting, and pay_valid, pay_last, hdr_valid, pkt_ok and pkt_err are all low.
- R2: While hunting, a byte other than the start flag (default 0xA5) produces no output strobe and does not start a packet.
- R3: After the start flag the next five bytes are, in order, the tag, the block number, the operation code, the length high byte and the length low byte. They appear on pkt_id, pkt_addr, pkt_type and pkt_len. hdr_valid pulses one clock after the length low byte.
- R4: The operation code must be 0x01 (set), 0x02 (query) or 0x03 (sort). Any other value raises pkt_err with err_code 0 one clock after the code byte.
- R5: Each payload byte appears on pay_data with pay_valid one clock after it is accepted. pay_last is high together with the final payload byte. A length of zero produces no payload strobe.
- R6: The check byte is a CRC-8 with polynomial 0x07, initial value 0x00, processed MSB first, over every byte from the tag through the last payload byte. A mismatch raises pkt_err with err_code 1 one clock after the check byte.
- R7: If the byte after a matching check byte is not the end flag (default 0x5A), pkt_err is raised with err_code 2.
- R8: Inside a packet, TIMEOUT consecutive clocks without in_valid raise pkt_err with err_code 3. A byte that arrives after TIMEOUT-1 idle clocks continues the packet normally.
- R9: pkt_ok pulses for exactly one clock, one clock after a correct end flag that follows a matching check byte.
- R10: After any error the parser hunts again, ignores the rest of the failed packet, and parses the next well-formed packet correctly.
- R11: pkt_ok and pkt_err are never high in the same clock, and pay_last is only high together with pay_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Input byte |
| pkt_id | output | 8 | Tracking tag of the current packet |
| pkt_addr | output | 8 | Target block number |
| pkt_type | output | 8 | Operation code |
| pkt_len | output | 16 | Payload byte count |
| hdr_valid | output | 1 | Header complete and operation code valid |
| pay_valid | output | 1 | Payload byte strobe |
| pay_data | output | 8 | Payload byte |
| pay_last | output | 1 | Final payload byte marker |
| pkt_ok | output | 1 | Packet good strobe |
| pkt_err | output | 1 | Packet error strobe |
| err_code | output | 2 | Error cause: 0 operation code, 1 CRC, 2 end flag, 3 timeout |

## Verification
Two functions can fall on the same clock: the expiry of the idle timer and the arrival of the next byte on the last clock before the limit. On that clock the byte must win. The bench provokes this by pausing exactly TIMEOUT-1 clocks inside a packet and then finishing it; a good strobe with no error confirms the byte won. It then pauses exactly TIMEOUT clocks and expects a timeout error, which confirms where the boundary lies. A second overlap is a good strobe in the same clock as a new start flag is accepted. Back-to-back packets with no gap cover this, and the bench expects both to be reported good.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 16;
  localparam int ERR_W  = 2;

  typedef enum logic [3:0] {
    ST_HUNT, ST_ID, ST_ADDR, ST_TYPE, ST_LENH, ST_LENL, ST_PAY, ST_CHK, ST_END
  } pstate_t;

  typedef enum logic [ERR_W-1:0] {
    ERR_TYPE    = 2'd0,
    ERR_CRC     = 2'd1,
    ERR_END     = 2'd2,
    ERR_TIMEOUT = 2'd3
  } perr_t;

  localparam logic [BYTE_W-1:0] OP_SET   = 8'h01;
  localparam logic [BYTE_W-1:0] OP_QUERY = 8'h02;
  localparam logic [BYTE_W-1:0] OP_SORT  = 8'h03;
  localparam logic [BYTE_W-1:0] CRC_POLY = 8'h07;
endpackage

// File: rtl/pkt_crc8.sv
module pkt_crc8
  import pkt_pkg::*;
(
  input  logic [BYTE_W-1:0] crc_in,
  input  logic [BYTE_W-1:0] data_in,
  output logic [BYTE_W-1:0] crc_out
);
  always_comb begin
    logic [BYTE_W-1:0] c;
    c = crc_in ^ data_in;
    for (int i = 0; i < BYTE_W; i++) begin
      c = c[BYTE_W-1] ? ((c << 1) ^ CRC_POLY) : (c << 1);
    end
    crc_out = c;
  end
endmodule

// File: rtl/pkt_idle_timer.sv
module pkt_idle_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic in_valid,
  output logic expire
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign expire = busy && !in_valid && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !busy || in_valid) cnt <= '0;
    else if (cnt != LAST)         cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pkt_parser.sv
module pkt_parser
  import pkt_pkg::*;
#(
  parameter logic [7:0] SOF_BYTE = 8'hA5,
  parameter logic [7:0] EOF_BYTE = 8'h5A,
  parameter int         TIMEOUT  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic [7:0]        pkt_id,
  output logic [7:0]        pkt_addr,
  output logic [7:0]        pkt_type,
  output logic [LEN_W-1:0]  pkt_len,
  output logic              hdr_valid,
  output logic              pay_valid,
  output logic [7:0]        pay_data,
  output logic              pay_last,
  output logic              pkt_ok,
  output logic              pkt_err,
  output logic [ERR_W-1:0]  err_code
);
  pstate_t          st;
  logic [7:0]       crc_q, crc_nx;
  logic [LEN_W-1:0] rem_q;
  logic             expire, type_ok;

  pkt_crc8 u_crc (.crc_in(crc_q), .data_in(in_byte), .crc_out(crc_nx));

  pkt_idle_timer #(.LIMIT(TIMEOUT)) u_tmr (
    .clk(clk), .rst(rst), .busy(st != ST_HUNT), .in_valid(in_valid), .expire(expire)
  );

  assign type_ok = (in_byte == OP_SET) || (in_byte == OP_QUERY) || (in_byte == OP_SORT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_HUNT;
      crc_q <= '0;
      rem_q <= '0;
      pkt_id <= '0;
      pkt_addr <= '0;
      pkt_type <= '0;
      pkt_len <= '0;
      hdr_valid <= 1'b0;
      pay_valid <= 1'b0;
      pay_data <= '0;
      pay_last <= 1'b0;
      pkt_ok <= 1'b0;
      pkt_err <= 1'b0;
      err_code <= '0;
    end else begin
      hdr_valid <= 1'b0;
      pay_valid <= 1'b0;
      pay_last  <= 1'b0;
      pkt_ok    <= 1'b0;
      pkt_err   <= 1'b0;
      if (expire) begin
        pkt_err  <= 1'b1;
        err_code <= ERR_TIMEOUT;
        st       <= ST_HUNT;
      end else if (in_valid) begin
        case (st)
          ST_HUNT: if (in_byte == SOF_BYTE) begin
            crc_q <= '0;
            st    <= ST_ID;
          end
          ST_ID: begin
            pkt_id <= in_byte;
            crc_q  <= crc_nx;
            st     <= ST_ADDR;
          end
          ST_ADDR: begin
            pkt_addr <= in_byte;
            crc_q    <= crc_nx;
            st       <= ST_TYPE;
          end
          ST_TYPE: begin
            pkt_type <= in_byte;
            crc_q    <= crc_nx;
            if (type_ok) st <= ST_LENH;
            else begin
              pkt_err  <= 1'b1;
              err_code <= ERR_TYPE;
              st       <= ST_HUNT;
            end
          end
          ST_LENH: begin
            pkt_len[LEN_W-1:8] <= in_byte;
            crc_q <= crc_nx;
            st    <= ST_LENL;
          end
          ST_LENL: begin
            pkt_len[7:0] <= in_byte;
            rem_q     <= {pkt_len[LEN_W-1:8], in_byte};
            crc_q     <= crc_nx;
            hdr_valid <= 1'b1;
            st <= ({pkt_len[LEN_W-1:8], in_byte} == '0) ? ST_CHK : ST_PAY;
          end
          ST_PAY: begin
            pay_valid <= 1'b1;
            pay_data  <= in_byte;
            pay_last  <= (rem_q == LEN_W'(1));
            rem_q     <= rem_q - 1'b1;
            crc_q     <= crc_nx;
            if (rem_q == LEN_W'(1)) st <= ST_CHK;
          end
          ST_CHK: begin
            if (in_byte == crc_q) st <= ST_END;
            else begin
              pkt_err  <= 1'b1;
              err_code <= ERR_CRC;
              st       <= ST_HUNT;
            end
          end
          ST_END: begin
            if (in_byte == EOF_BYTE) pkt_ok <= 1'b1;
            else begin
              pkt_err  <= 1'b1;
              err_code <= ERR_END;
            end
            st <= ST_HUNT;
          end
          default: st <= ST_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/pkt_parser_chk.sv
module pkt_parser_chk #(
  parameter logic [7:0] EOF_BYTE = 8'h5A
) (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic [7:0] in_byte,
  input logic       pay_valid,
  input logic       pay_last,
  input logic       pkt_ok,
  input logic       pkt_err,
  input logic [1:0] err_code
);
  a_r11_ok_err_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(pkt_ok && pkt_err));

  a_r11_last_with_valid: assert property (@(posedge clk) disable iff (rst)
    pay_last |-> pay_valid);

  a_r9_ok_single_pulse: assert property (@(posedge clk) disable iff (rst)
    pkt_ok |=> !pkt_ok);

  a_r9_ok_after_end_flag: assert property (@(posedge clk) disable iff (rst)
    pkt_ok |-> ($past(in_valid) && $past(in_byte) == EOF_BYTE));

  a_r5_payload_follows_input: assert property (@(posedge clk) disable iff (rst)
    pay_valid |-> $past(in_valid));

  a_r8_timeout_on_idle: assert property (@(posedge clk) disable iff (rst)
    (pkt_err && err_code == 2'd3) |-> !$past(in_valid));

  a_r7_end_err_on_byte: assert property (@(posedge clk) disable iff (rst)
    (pkt_err && err_code == 2'd2) |-> ($past(in_valid) && $past(in_byte) != EOF_BYTE));
endmodule

bind pkt_parser pkt_parser_chk #(.EOF_BYTE(EOF_BYTE)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
  .pay_valid(pay_valid), .pay_last(pay_last), .pkt_ok(pkt_ok),
  .pkt_err(pkt_err), .err_code(err_code)
);

// File: tb/test_pkt_parser.sv
module test_pkt_parser;
  localparam int TO = 16;
  localparam logic [7:0] SOF = 8'hA5;
  localparam logic [7:0] EOFB = 8'h5A;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic [7:0] pkt_id, pkt_addr, pkt_type, pay_data;
  logic [15:0] pkt_len;
  logic hdr_valid, pay_valid, pay_last, pkt_ok, pkt_err;
  logic [1:0] err_code;

  int checks = 0, errors = 0;
  int ok_n, err_n, hdr_n, pay_n, last_idx, last_n;
  logic [1:0] err_seen;
  logic [7:0] rx_pay [0:31];
  logic [7:0] tx_pay [0:31];

  always #4 clk = ~clk;

  pkt_parser #(.SOF_BYTE(SOF), .EOF_BYTE(EOFB), .TIMEOUT(TO)) i_pkt_parser (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .pkt_id(pkt_id), .pkt_addr(pkt_addr), .pkt_type(pkt_type), .pkt_len(pkt_len),
    .hdr_valid(hdr_valid), .pay_valid(pay_valid), .pay_data(pay_data),
    .pay_last(pay_last), .pkt_ok(pkt_ok), .pkt_err(pkt_err), .err_code(err_code)
  );

  always @(negedge clk) if (!rst) begin
    if (pay_valid) begin
      if (pay_n < 32) rx_pay[pay_n] = pay_data;
      if (pay_last) begin last_idx = pay_n; last_n++; end
      pay_n++;
    end
    if (pkt_ok) ok_n++;
    if (pkt_err) begin err_n++; err_seen = err_code; end
    if (hdr_valid) hdr_n++;
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung, expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr();
    ok_n = 0; err_n = 0; hdr_n = 0; pay_n = 0; last_idx = -1; last_n = 0; err_seen = '0;
  endtask

  task automatic put(logic [7:0] b);
    in_valid = 1'b1; in_byte = b;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  function automatic logic [7:0] crc_add(logic [7:0] c, logic [7:0] d);
    logic [7:0] r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  task automatic send_pkt(logic [7:0] id, logic [7:0] ad, logic [7:0] ty, int len,
                          logic [7:0] crc_xor, logic [7:0] endb);
    logic [7:0] c = 8'h00;
    put(SOF);
    put(id); c = crc_add(c, id);
    put(ad); c = crc_add(c, ad);
    put(ty); c = crc_add(c, ty);
    put(8'(len >> 8)); c = crc_add(c, 8'(len >> 8));
    put(8'(len)); c = crc_add(c, 8'(len));
    for (int i = 0; i < len; i++) begin put(tx_pay[i]); c = crc_add(c, tx_pay[i]); end
    put(c ^ crc_xor);
    put(endb);
  endtask

  task automatic t_reset();
    chk("R1 pkt_ok", int'(pkt_ok), 0);
    chk("R1 pkt_err", int'(pkt_err), 0);
    chk("R1 pay_valid", int'(pay_valid), 0);
    chk("R1 hdr_valid", int'(hdr_valid), 0);
  endtask

  task automatic t_garbage();
    clr();
    put(8'h00); put(EOFB); put(8'hFF); put(8'h13); idle(3);
    chk("R2 no strobes", ok_n + err_n + hdr_n + pay_n, 0);
  endtask

  task automatic t_good();
    clr();
    tx_pay[0] = 8'h11; tx_pay[1] = 8'h22; tx_pay[2] = 8'h33;
    send_pkt(8'h42, 8'h07, 8'h03, 3, 8'h00, EOFB); idle(3);
    chk("R3 id", int'(pkt_id), 'h42);
    chk("R3 addr", int'(pkt_addr), 'h07);
    chk("R3 type", int'(pkt_type), 'h03);
    chk("R3 len", int'(pkt_len), 3);
    chk("R3 hdr_valid", hdr_n, 1);
    chk("R5 count", pay_n, 3);
    chk("R5 byte0", int'(rx_pay[0]), 'h11);
    chk("R5 byte2", int'(rx_pay[2]), 'h33);
    chk("R5 last idx", last_idx, 2);
    chk("R6 R9 ok", ok_n, 1);
    chk("R9 no err", err_n, 0);
  endtask

  task automatic t_zero_len();
    clr();
    send_pkt(8'h01, 8'h02, 8'h01, 0, 8'h00, EOFB); idle(3);
    chk("R5 zero len no payload", pay_n, 0);
    chk("R9 zero len ok", ok_n, 1);
  endtask

  task automatic t_bad_type();
    clr();
    put(SOF); put(8'h09); put(8'h01); put(8'h07); idle(2);
    chk("R4 err", err_n, 1);
    chk("R4 code", int'(err_seen), 0);
    put(8'h00); put(8'h01); put(8'h44); put(8'h12); put(EOFB); idle(2);
    chk("R10 rest ignored", ok_n + err_n + hdr_n + pay_n - 1, 0);
    tx_pay[0] = 8'h9C;
    send_pkt(8'h10, 8'h20, 8'h02, 1, 8'h00, EOFB); idle(3);
    chk("R10 recovery ok", ok_n, 1);
    chk("R10 recovery payload", int'(rx_pay[0]), 'h9C);
  endtask

  task automatic t_bad_crc();
    clr();
    tx_pay[0] = 8'hDE; tx_pay[1] = 8'hAD;
    send_pkt(8'h33, 8'h44, 8'h01, 2, 8'h01, EOFB); idle(3);
    chk("R6 err", err_n, 1);
    chk("R6 code", int'(err_seen), 1);
    chk("R6 no ok", ok_n, 0);
  endtask

  task automatic t_no_end();
    clr();
    tx_pay[0] = 8'h77;
    send_pkt(8'h55, 8'h66, 8'h02, 1, 8'h00, 8'h00); idle(3);
    chk("R7 err", err_n, 1);
    chk("R7 code", int'(err_seen), 2);
    chk("R7 no ok", ok_n, 0);
  endtask

  task automatic t_timeout();
    logic [7:0] c;
    clr();
    c = crc_add(crc_add(crc_add(crc_add(crc_add(8'h00, 8'h61), 8'h62), 8'h01), 8'h00), 8'h00);
    put(SOF); put(8'h61); idle(TO - 1);
    put(8'h62); put(8'h01); put(8'h00); put(8'h00); put(c); put(EOFB); idle(3);
    chk("R8 gap below limit no err", err_n, 0);
    chk("R8 gap below limit ok", ok_n, 1);
    clr();
    put(SOF); put(8'h61); idle(TO - 1);
    chk("R8 not yet", err_n, 0);
    idle(3);
    chk("R8 timeout err", err_n, 1);
    chk("R8 timeout code", int'(err_seen), 3);
  endtask

  task automatic t_back_to_back();
    clr();
    tx_pay[0] = 8'hA5; tx_pay[1] = 8'h5A;
    send_pkt(8'h01, 8'h01, 8'h03, 2, 8'h00, EOFB);
    send_pkt(8'h02, 8'h02, 8'h01, 0, 8'h00, EOFB); idle(3);
    chk("R9 back to back ok", ok_n, 2);
    chk("R11 no err", err_n, 0);
    chk("R5 flag-valued payload", int'(rx_pay[0]), 'hA5);
    chk("R5 single last", last_n, 1);
  endtask

  initial begin
    clr();
    idle(3);
    t_reset();
    rst = 1'b0;
    idle(2);
    t_garbage();
    t_good();
    t_zero_len();
    t_bad_type();
    t_bad_crc();
    t_no_end();
    t_timeout();
    t_back_to_back();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule